// File: doc/BRIEF.md
# Conversion-Complete Flag Clear Controller

This block keeps one conversion-complete flag for each of the converter's result channels (16 by default). A sequencer pulse for a channel sets that channel's flag. Software can clear a flag in two ways:

- by writing a one to its bit in the flag register, or
- when the fast-clear control bit is set, by accessing the channel's result register.

With fast clear, each channel's compare-enable input picks which access clears its flag. If compare is off, a read of the result register clears it. If compare is on, a write clears it.

The register bus is a plain single-cycle interface with an address, a read strobe, a write strobe and write data. Reads return data combinationally on `rdata_o`. The result data itself lives elsewhere. This block only sees the accesses to the result addresses.

Address map:

| Address | Contents |
|---|---|
| 0x00 | Control register. Bit 0 is the fast-clear enable. |
| 0x01 | Flag register. Bit n is channel n. |
| 0x10 + n | Result register of channel n. |

Reads of any other address return 0.

Top module: `ccf_clear_ctrl`

## Requirements
- R1: While `rst_ni` is low, every flag and the fast-clear bit are 0; the reset is asynchronous.
- R2: A one on `set_i[n]` makes `flags_o[n]` 1 at the next rising clock edge.
- R3: A write to address 0x01 clears each flag whose `wdata_i` bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: With fast clear off (control bit 0 = 0), reads and writes of result addresses 0x10+n change no flag.
- R5: With fast clear on and `cmp_en_i[n]` = 0, a read of address 0x10+n clears flag n. A write to it does not.
- R6: With fast clear on and `cmp_en_i[n]` = 1, a write to address 0x10+n clears flag n. A read of it does not.
- R7: With fast clear on, write-one-to-clear through address 0x01 still clears flags.
- R8: When a set pulse and a clear event hit the same flag in the same cycle, the flag ends up 1.
- R9: An access to channel n's result address never changes the flag of any other channel.
- R10: The fast-clear bit is written from `wdata_i[0]` at address 0x00 at any time. A read of 0x00 returns it in `rdata_o[0]`, and a read of 0x01 returns the flag vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 16 | Write data |
| set_i | input | 16 | Per-channel result-written pulse from the sequencer |
| cmp_en_i | input | 16 | Per-channel compare-enable |
| rdata_o | output | 16 | Read data, combinational from the address |
| flags_o | output | 16 | Conversion-complete flag vector |

## Verification
The flag and control registers are one flop deep. A set pulse, a clear access or a control write issued in one cycle therefore shows on `flags_o` one rising edge later. The bench drives each stimulus on a falling edge and holds it for exactly one cycle. It compares `flags_o` at the following falling edge, which lies after the single register stage.

`rdata_o` is combinational. It is checked a moment after the inputs are driven, before the edge that would consume the access. Reset is asynchronous, so it is checked a moment after `rst_ni` falls, with no clock edge in between.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/ccf_bus_dec.sv
module ccf_bus_dec #(
  parameter int unsigned NCH       = 16,
  parameter int unsigned AW        = 6,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned FLAG_ADDR = 1,
  parameter int unsigned RES_BASE  = 16
) (
  input  logic [AW-1:0]  addr_i,
  input  logic           rd_i,
  input  logic           wr_i,
  output logic           ctrl_wr_o,
  output logic           ctrl_rd_o,
  output logic           flag_wr_o,
  output logic           flag_rd_o,
  output logic [NCH-1:0] res_rd_o,
  output logic [NCH-1:0] res_wr_o
);
  localparam logic [AW-1:0] CtrlA = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] FlagA = AW'(FLAG_ADDR);

  assign ctrl_wr_o = wr_i && (addr_i == CtrlA);
  assign ctrl_rd_o = rd_i && (addr_i == CtrlA);
  assign flag_wr_o = wr_i && (addr_i == FlagA);
  assign flag_rd_o = rd_i && (addr_i == FlagA);

  for (genvar k = 0; k < NCH; k++) begin : g_res
    localparam logic [AW-1:0] ResA = AW'(RES_BASE + k);
    assign res_rd_o[k] = rd_i && (addr_i == ResA);
    assign res_wr_o[k] = wr_i && (addr_i == ResA);
  end
endmodule

// File: rtl/ccf_ctrl_reg.sv
module ccf_ctrl_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wbit_i,
  output logic fast_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fast_clr_o <= 1'b0;
    else if (wr_en_i) fast_clr_o <= wbit_i;
  end
endmodule

// File: rtl/ccf_flag_bit.sv
module ccf_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority so a completion is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/ccf_clear_ctrl.sv
module ccf_clear_ctrl #(
  parameter int unsigned NCH       = 16,
  parameter int unsigned AW        = 6,
  parameter int unsigned DW        = 16,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned FLAG_ADDR = 1,
  parameter int unsigned RES_BASE  = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic           rd_i,
  input  logic           wr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] cmp_en_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] flags_o
);
  logic           ctrl_wr, ctrl_rd, flag_wr, flag_rd;
  logic [NCH-1:0] res_rd, res_wr, clr;
  logic           fast_clr;

  ccf_bus_dec #(
    .NCH(NCH), .AW(AW), .CTRL_ADDR(CTRL_ADDR),
    .FLAG_ADDR(FLAG_ADDR), .RES_BASE(RES_BASE)
  ) u_dec (
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .ctrl_wr_o(ctrl_wr), .ctrl_rd_o(ctrl_rd),
    .flag_wr_o(flag_wr), .flag_rd_o(flag_rd),
    .res_rd_o(res_rd), .res_wr_o(res_wr)
  );

  ccf_ctrl_reg u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(ctrl_wr), .wbit_i(wdata_i[0]),
    .fast_clr_o(fast_clr)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    // compare-enabled channels clear on result write, others on result read
    assign clr[k] = (flag_wr && wdata_i[k]) ||
                    (fast_clr && (cmp_en_i[k] ? res_wr[k] : res_rd[k]));
    ccf_flag_bit u_bit (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(set_i[k]), .clr_i(clr[k]),
      .q_o(flags_o[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_rd)      rdata_o[0] = fast_clr;
    else if (flag_rd) rdata_o[NCH-1:0] = flags_o;
  end
endmodule

// File: rtl/ccf_clear_ctrl_chk.sv
module ccf_clear_ctrl_chk #(
  parameter int unsigned NCH       = 16,
  parameter int unsigned AW        = 6,
  parameter int unsigned DW        = 16,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned FLAG_ADDR = 1,
  parameter int unsigned RES_BASE  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [AW-1:0]  addr_i,
  input logic           rd_i,
  input logic           wr_i,
  input logic [DW-1:0]  wdata_i,
  input logic [NCH-1:0] set_i,
  input logic [NCH-1:0] cmp_en_i,
  input logic [DW-1:0]  rdata_o,
  input logic [NCH-1:0] flags_o,
  input logic           fast_clr
);
  localparam logic [AW-1:0] CtrlA = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] FlagA = AW'(FLAG_ADDR);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (flags_o == '0 && !fast_clr));

  // R10
  a_r10_ctrl_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == CtrlA) |-> (rdata_o[0] == fast_clr));

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    localparam logic [AW-1:0] ResA = AW'(RES_BASE + k);

    // R2, R8
    a_r2_set_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flags_o[k]);

    // R3
    a_r3_zero_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == FlagA && !wdata_i[k] && flags_o[k]) |=> flags_o[k]);

    // R4
    a_r4_no_fast_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fast_clr && (rd_i || wr_i) && addr_i == ResA && flags_o[k]) |=> flags_o[k]);

    // R5
    a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fast_clr && rd_i && !wr_i && addr_i == ResA && !cmp_en_i[k] && !set_i[k])
      |=> !flags_o[k]);

    // R6
    a_r6_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fast_clr && wr_i && addr_i == ResA && cmp_en_i[k] && !set_i[k])
      |=> !flags_o[k]);

    // R9: flag falls only after a write to the flag register or own result access
    a_r9_no_foreign_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flags_o[k]) |->
        $past(wr_i && (addr_i == FlagA || addr_i == ResA) || rd_i && addr_i == ResA));
  end
endmodule

bind ccf_clear_ctrl ccf_clear_ctrl_chk #(
  .NCH(NCH), .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR),
  .FLAG_ADDR(FLAG_ADDR), .RES_BASE(RES_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
  .wdata_i(wdata_i), .set_i(set_i), .cmp_en_i(cmp_en_i),
  .rdata_o(rdata_o), .flags_o(flags_o), .fast_clr(fast_clr)
);

// File: tb/ccf_clear_ctrl_test.sv
module ccf_clear_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] CTRL = 6'h00;
  localparam logic [5:0] FLAG = 6'h01;
  localparam logic [5:0] RB   = 6'h10;
  localparam logic [1:0] IDL = 2'd0, RD = 2'd1, WR = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  addr;
    logic [15:0] wdata;
    logic [15:0] set;
    logic [15:0] cmp;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{IDL, CTRL,      16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 4'd2},  // R2 set all
    '{WR,  FLAG,      16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 4'd3},  // R3 zeros ignored
    '{WR,  FLAG,      16'h0005, 16'h0000, 16'h0000, 16'hFFFA, 4'd3},  // R3 w1c
    '{RD,  RB+6'd1,   16'h0000, 16'h0000, 16'h0000, 16'hFFFA, 4'd4},  // R4 read, fc off
    '{WR,  RB+6'd3,   16'h0000, 16'h0000, 16'hFFFF, 16'hFFFA, 4'd4},  // R4 write, fc off
    '{WR,  CTRL,      16'h0001, 16'h0000, 16'h0000, 16'hFFFA, 4'd10}, // R10 fc on
    '{RD,  RB+6'd1,   16'h0000, 16'h0000, 16'h0000, 16'hFFF8, 4'd5},  // R5, R9
    '{WR,  RB+6'd3,   16'h0000, 16'h0000, 16'h0000, 16'hFFF8, 4'd5},  // R5 write no clear
    '{RD,  RB+6'd3,   16'h0000, 16'h0000, 16'h0008, 16'hFFF8, 4'd6},  // R6 read no clear
    '{WR,  RB+6'd3,   16'h0000, 16'h0000, 16'h0008, 16'hFFF0, 4'd6},  // R6 write clears
    '{RD,  RB+6'd15,  16'h0000, 16'h8000, 16'h0000, 16'hFFF0, 4'd8},  // R8 set wins
    '{WR,  FLAG,      16'hF000, 16'h0000, 16'h0000, 16'h0FF0, 4'd7},  // R7 w1c in fc
    '{WR,  RB+6'd4,   16'h0000, 16'h0001, 16'h0010, 16'h0FE1, 4'd9},  // R9, R2
    '{WR,  FLAG,      16'h0001, 16'h0001, 16'h0000, 16'h0FE1, 4'd8},  // R8 w1c vs set
    '{WR,  CTRL,      16'h0000, 16'h0000, 16'h0000, 16'h0FE1, 4'd10}, // R10 fc off
    '{RD,  RB+6'd5,   16'h0000, 16'h0000, 16'h0000, 16'h0FE1, 4'd4}   // R4 after fc off
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [15:0] wdata_i = '0, set_i = '0, cmp_en_i = '0;
  logic [15:0] rdata_o, flags_o;
  int applied = 0, errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ccf_clear_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .set_i(set_i), .cmp_en_i(cmp_en_i),
    .rdata_o(rdata_o), .flags_o(flags_o)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input int r);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [5:0] a, input logic [15:0] wd,
                       input logic [15:0] st, input logic [15:0] cm);
    rd_i = (op == RD); wr_i = (op == WR);
    addr_i = a; wdata_i = wd; set_i = st; cmp_en_i = cm;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(flags_o, 16'h0000, 1);                 // R1 flags
    drive(RD, CTRL, 0, 0, 0); #1;
    check(rdata_o, 16'h0000, 1);                 // R1 fast-clear bit
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].set, VECS[i].cmp);
      @(negedge clk_i);
      check(flags_o, VECS[i].exp, int'(VECS[i].req));
    end
    drive(RD, FLAG, 0, 0, 0); #1;
    check(rdata_o, 16'h0FE1, 10);                // R10 flag readback
    drive(WR, CTRL, 16'h0001, 0, 0);
    @(negedge clk_i);
    drive(RD, CTRL, 0, 0, 0); #1;
    check(rdata_o, 16'h0001, 10);                // R10 ctrl readback
    @(negedge clk_i);
    drive(RD, RB + 6'd11, 0, 0, 16'h0800);       // R6: read with compare keeps flag
    @(negedge clk_i);
    check(flags_o, 16'h0FE1, 6);
    drive(RD, RB + 6'd11, 0, 0, 16'h0000);       // R5: read without compare clears
    @(negedge clk_i);
    check(flags_o, 16'h07E1, 5);
    drive(IDL, CTRL, 0, 0, 0);
    @(negedge clk_i);
    #1 rst_ni = 1'b0; #1;
    check(flags_o, 16'h0000, 1);                 // R1 async reset mid-run
    drive(RD, CTRL, 0, 0, 0); #1;
    check(rdata_o, 16'h0000, 1);
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule